// File: doc/BRIEF.md
# Compressed Instruction Pair Sequencer

This block sits between instruction fetch and instruction decode. Fetch hands it one 32-bit word at a time. The block looks at the major opcode in bits 31:26 of that word. Most words are ordinary 32-bit instructions and pass straight through to decode. A word whose opcode is one of two reserved values holds two 16-bit compressed instructions instead. The block sends those to decode one after the other, the upper halfword first and the lower halfword second.

The position inside a pair is held in a state bit of its own, `hs_q`. It is not worked out from program-counter alignment, because a 48-bit instruction can legitimately leave the counter on a 2-byte boundary. When a trap arrives, issue stops and the bit holds its value. The handler reads `hs_q`, and it writes the value back later through `hs_wr_en`/`hs_wr_val`. A pair that was interrupted between its halves then resumes at the correct half. The block also pulses `pc_adv4` to tell fetch when the word has been fully consumed.

Both data edges use a valid/ready handshake. A transfer happens on a clock edge where valid and ready are both high. The decode side may hold `out_ready` low for any number of cycles. While it does, nothing is consumed and the state does not move. The fetch side must hold `in_word` steady while `in_valid` is high and `in_ready` is low. The output is driven combinationally from the fetch word and the state bit, so the block adds no cycle of latency.

Top module: `cpair_seq`

## Requirements
- R1: A word whose bits 31:26 match neither pair opcode is issued unchanged on `out_insn`. It is issued with `out_is_c16`=0 and `out_is_nop`=0, with `in_ready` equal to `out_ready`, and with `pc_adv4` high in the cycle it transfers.
- R2: The two pair opcodes are the parameters `PAIR_OP_A` (default 6'h05) and `PAIR_OP_B` (default 6'h07). Either value in bits 31:26 marks the word as a compressed pair. Any neighbouring value, such as 6'h06, does not.
- R3: When `hs_q`=0, a pair word issues bits 31:16 on `out_insn[15:0]`, with `out_insn[31:16]`=0 and `out_is_c16`=1. During this issue `in_ready` and `pc_adv4` stay low, and once the issue is accepted `hs_q` becomes 1.
- R4: When `hs_q`=1, a pair word issues bits 15:0 in the same form. During this issue `in_ready` equals `out_ready`, `pc_adv4` is high when the issue is accepted, and `hs_q` then returns to 0.
- R5: A compressed half whose 16 bits are all zero is issued with `out_is_nop`=1 and still takes one issue slot. Such a half is possible only in the lower halfword under the default opcodes.
- R6: Reset clears `hs_q` to 0. After reset, `out_valid` is low whenever `in_valid` is low.
- R7: `hs_wr_en`=1 loads `hs_wr_val` into `hs_q` at the next edge. This write takes priority over any half-select change that an accepted issue would cause in the same cycle.
- R8: While `trap` is high, `out_valid`, `in_ready` and `pc_adv4` are low and `hs_q` holds its value (unless it is written).
- R9: While `out_ready` is low, `in_ready` and `pc_adv4` are low and `hs_q` does not change.
- R10: After `hs_q` has been restored to 1, the next pair word issues only its lower halfword and then advances the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fetch word is present |
| in_ready | output | 1 | Fetch word is consumed at this edge |
| in_word | input | 32 | Fetched instruction word |
| out_valid | output | 1 | Issue item is present |
| out_ready | input | 1 | Decode accepts the item |
| out_insn | output | 32 | Issued instruction; a compressed half sits in bits 15:0 |
| out_is_c16 | output | 1 | Item is a 16-bit compressed half |
| out_is_nop | output | 1 | Item is an all-zero compressed half |
| pc_adv4 | output | 1 | Program counter advances by 4 at this edge |
| trap | input | 1 | Trap in progress; stop issuing |
| hs_q | output | 1 | Current half-select bit (0 = upper next) |
| hs_wr_en | input | 1 | Restore strobe for the half-select bit |
| hs_wr_val | input | 1 | Value to restore |

## Verification
If the half-select bit is wrong, the very next pair word is issued with the wrong halfword on `out_insn`. The same error also flips `in_ready` and `pc_adv4` in that cycle. The fault therefore shows at the ports in the same cycle as the first affected issue, and a skipped or duplicated half shows as a wrong number of issues before `pc_adv4`. The checks watch the halfword order across stalls, across traps and across restores. They also check the priority of a restore write over an accepted issue.

// File: rtl/cpair_pkg.sv
package cpair_pkg;
  typedef enum logic {
    KIND_N32 = 1'b0,
    KIND_C16 = 1'b1
  } item_kind_e;

  function automatic logic all_zero16(input logic [15:0] h);
    return (h == 16'h0000);
  endfunction
endpackage

// File: rtl/cpair_classify.sv
module cpair_classify #(
  parameter int WORD_W = 32,
  parameter int OPC_W = 6,
  parameter logic [OPC_W-1:0] PAIR_OP_A = 6'h05,
  parameter logic [OPC_W-1:0] PAIR_OP_B = 6'h07
) (
  input  logic [WORD_W-1:0] word,
  output logic              is_pair
);
  localparam int NUM_OPS = 2;
  logic [OPC_W-1:0] opc;
  logic [NUM_OPS-1:0] hit;

  assign opc = word[WORD_W-1 -: OPC_W];

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_match
    localparam logic [OPC_W-1:0] REF = (i == 0) ? PAIR_OP_A : PAIR_OP_B;
    assign hit[i] = (opc == REF);
  end

  assign is_pair = |hit;
endmodule

// File: rtl/cpair_halfsel.sv
module cpair_halfsel (
  input  logic clk,
  input  logic rst_n,
  input  logic take_first,
  input  logic take_second,
  input  logic wr_en,
  input  logic wr_val,
  output logic q
);
  logic q_nxt;

  always_comb begin
    q_nxt = q;
    if (wr_en)            q_nxt = wr_val;
    else if (take_first)  q_nxt = 1'b1;
    else if (take_second) q_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/cpair_issue.sv
module cpair_issue
  import cpair_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_word,
  input  logic              is_pair,
  input  logic              half,
  input  logic              trap,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_insn,
  output item_kind_e        out_kind,
  output logic              out_nop,
  output logic              take_first,
  output logic              take_second,
  output logic              pc_adv4
);
  localparam int HALF_W = WORD_W / 2;

  logic [HALF_W-1:0] hw;
  logic fire;
  logic last_part;

  assign hw        = half ? in_word[HALF_W-1:0] : in_word[WORD_W-1:HALF_W];
  assign out_valid = in_valid && !trap;
  assign fire      = out_valid && out_ready;
  assign last_part = !is_pair || half;

  assign in_ready    = out_ready && !trap && last_part;
  assign pc_adv4     = fire && last_part;
  assign take_first  = fire && is_pair && !half;
  assign take_second = fire && is_pair && half;

  always_comb begin
    if (is_pair) begin
      out_insn = {{(WORD_W-HALF_W){1'b0}}, hw};
      out_kind = KIND_C16;
      out_nop  = all_zero16(hw);
    end else begin
      out_insn = in_word;
      out_kind = KIND_N32;
      out_nop  = 1'b0;
    end
  end
endmodule

// File: rtl/cpair_seq.sv
module cpair_seq
  import cpair_pkg::*;
#(
  parameter logic [5:0] PAIR_OP_A = 6'h05,
  parameter logic [5:0] PAIR_OP_B = 6'h07
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_word,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_insn,
  output logic        out_is_c16,
  output logic        out_is_nop,
  output logic        pc_adv4,
  input  logic        trap,
  output logic        hs_q,
  input  logic        hs_wr_en,
  input  logic        hs_wr_val
);
  localparam int WORD_W = 32;
  localparam int OPC_W = 6;

  logic       is_pair;
  logic       take_first;
  logic       take_second;
  item_kind_e kind;

  cpair_classify #(
    .WORD_W(WORD_W), .OPC_W(OPC_W),
    .PAIR_OP_A(PAIR_OP_A), .PAIR_OP_B(PAIR_OP_B)
  ) u_cls (
    .word(in_word),
    .is_pair(is_pair)
  );

  cpair_halfsel u_hs (
    .clk(clk), .rst_n(rst_n),
    .take_first(take_first), .take_second(take_second),
    .wr_en(hs_wr_en), .wr_val(hs_wr_val),
    .q(hs_q)
  );

  cpair_issue #(.WORD_W(WORD_W)) u_iss (
    .in_valid(in_valid), .in_word(in_word), .is_pair(is_pair),
    .half(hs_q), .trap(trap), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .out_insn(out_insn),
    .out_kind(kind), .out_nop(out_is_nop),
    .take_first(take_first), .take_second(take_second),
    .pc_adv4(pc_adv4)
  );

  assign out_is_c16 = (kind == KIND_C16);
endmodule

// File: rtl/cpair_seq_chk.sv
module cpair_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_insn,
  input logic        out_is_c16,
  input logic        out_is_nop,
  input logic        pc_adv4,
  input logic        trap,
  input logic        hs_q,
  input logic        hs_wr_en,
  input logic        hs_wr_val
);
  AST_TRAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> (!out_valid && !in_ready && !pc_adv4)); // R8
  AST_ADV_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
    pc_adv4 |-> (in_valid && in_ready && out_valid && out_ready)); // R4
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_ready && !hs_wr_en) |=> $stable(hs_q)); // R9
  AST_NOP_IS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    out_is_nop |-> out_is_c16); // R5
  AST_HALF_ZERO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_c16) |-> (out_insn[31:16] == 16'h0)); // R3
  AST_FIRST_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_is_c16 && !hs_q && !hs_wr_en) |=> hs_q); // R3
  AST_RESTORE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    hs_wr_en |=> (hs_q == $past(hs_wr_val))); // R7
endmodule

bind cpair_seq cpair_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_insn(out_insn),
  .out_is_c16(out_is_c16), .out_is_nop(out_is_nop), .pc_adv4(pc_adv4),
  .trap(trap), .hs_q(hs_q), .hs_wr_en(hs_wr_en), .hs_wr_val(hs_wr_val)
);

// File: tb/sim_cpair_seq.sv
module sim_cpair_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_word = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_insn;
  logic        out_is_c16;
  logic        out_is_nop;
  logic        pc_adv4;
  logic        trap = 1'b0;
  logic        hs_q;
  logic        hs_wr_en = 1'b0;
  logic        hs_wr_val = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpair_seq u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
    .out_insn(out_insn), .out_is_c16(out_is_c16), .out_is_nop(out_is_nop),
    .pc_adv4(pc_adv4), .trap(trap), .hs_q(hs_q),
    .hs_wr_en(hs_wr_en), .hs_wr_val(hs_wr_val)
  );

  typedef struct packed {
    logic [31:0] word;
    logic        rdy;
    logic [31:0] e_insn;
    logic        e_c16;
    logic        e_nop;
    logic        e_ir;
    logic        e_adv;
    logic        e_hs;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{32'h8000_1234, 1'b1, 32'h8000_1234, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{32'h1432_ABCD, 1'b1, 32'h0000_1432, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h1432_ABCD, 1'b0, 32'h0000_ABCD, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    '{32'h1432_ABCD, 1'b1, 32'h0000_ABCD, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
    '{32'h1C55_0000, 1'b1, 32'h0000_1C55, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h1C55_0000, 1'b1, 32'h0000_0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1},
    '{32'h1800_0001, 1'b1, 32'h1800_0001, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
    '{32'h1400_5555, 1'b0, 32'h0000_1400, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h1400_5555, 1'b1, 32'h0000_1400, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h1400_5555, 1'b1, 32'h0000_5555, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R6 hs after reset", {31'd0, hs_q}, 32'd0);
    chk("R6 idle out_valid", {31'd0, out_valid}, 32'd0);

    // table walk: R1 R2 R3 R4 R5 R9
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      in_valid  = 1'b1;
      in_word   = TBL[i].word;
      out_ready = TBL[i].rdy;
      #1;
      chk($sformatf("R1-4 vec%0d hs", i), {31'd0, hs_q}, {31'd0, TBL[i].e_hs});
      chk($sformatf("R3 R4 vec%0d insn", i), out_insn, TBL[i].e_insn);
      chk($sformatf("R2 vec%0d c16", i), {31'd0, out_is_c16}, {31'd0, TBL[i].e_c16});
      chk($sformatf("R5 vec%0d nop", i), {31'd0, out_is_nop}, {31'd0, TBL[i].e_nop});
      chk($sformatf("R9 vec%0d in_ready", i), {31'd0, in_ready}, {31'd0, TBL[i].e_ir});
      chk($sformatf("R1 vec%0d pc_adv4", i), {31'd0, pc_adv4}, {31'd0, TBL[i].e_adv});
    end

    // R8: trap after first half
    @(negedge clk);
    in_word = 32'h1432_ABCD; out_ready = 1'b1;
    @(negedge clk);
    trap = 1'b1;
    #1;
    chk("R8 out_valid under trap", {31'd0, out_valid}, 32'd0);
    chk("R8 in_ready under trap", {31'd0, in_ready}, 32'd0);
    chk("R8 hs after first half", {31'd0, hs_q}, 32'd1);
    @(negedge clk);
    #1;
    chk("R8 hs held", {31'd0, hs_q}, 32'd1);

    // R7: restore writes
    hs_wr_en = 1'b1; hs_wr_val = 1'b0;
    @(negedge clk);
    #1;
    chk("R7 write 0", {31'd0, hs_q}, 32'd0);
    hs_wr_val = 1'b1;
    @(negedge clk);
    hs_wr_en = 1'b0; trap = 1'b0;
    #1;
    chk("R7 write 1", {31'd0, hs_q}, 32'd1);
    // R10: resume lower half only
    chk("R10 lower half", out_insn, 32'h0000_ABCD);
    chk("R10 adv", {31'd0, pc_adv4}, 32'd1);
    chk("R10 in_ready", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    #1;
    chk("R10 hs back to 0", {31'd0, hs_q}, 32'd0);
    chk("R10 next word upper", out_insn, 32'h0000_1432);

    // R7: write beats first-half advance
    hs_wr_en = 1'b1; hs_wr_val = 1'b0;
    @(negedge clk);
    hs_wr_en = 1'b0; in_valid = 1'b0;
    #1;
    chk("R7 write priority", {31'd0, hs_q}, 32'd0);
    chk("R6 idle after", {31'd0, out_valid}, 32'd0);

    finish_run();
  end
endmodule